// File: doc/BRIEF.md
# Inter-processor and timer interrupt unit

This unit holds two per-processor interrupt sources for a system of up to four processors. One source is the inter-processor interrupt, which one processor raises on another. The other is the periodic timer interrupt, which a tick input posts to all processors at once. Each source keeps one pending bit per processor, and each pending bit drives its own level output. The two outputs sit at different interrupt priority levels in the processor.

Software works the unit through a simple 64-bit register port that uses word addresses. A shared control word carries three processor masks in one write: raise inter-processor interrupts, drop inter-processor interrupts, and drop timer interrupts. Three dedicated registers apply the same operations one mask at a time, and two of them also read back the pending vectors. Two cases raise a one-cycle per-processor flag: a request for an interrupt that is already pending, and a clear for one that is not pending. A write that does nothing raises a one-cycle error flag and leaves all state unchanged.

Top module: `xcpu_irq_hub`

## Requirements
- R1: While `rstN` is low, every pending bit, interrupt output, flag and `rdValid` is 0.
- R2: A write to word address 0 raises, from the next cycle, the inter-processor pending bit and `ipiIrq` line of every processor selected in data bits 15:12 (bit 12 is processor 0).
- R3: In the same address-0 write, bits 11:8 select processors whose inter-processor interrupt is dropped, and bits 7:4 select processors whose timer interrupt is dropped. When one write both drops and raises the same processor, that processor's bit ends up set.
- R4: A request for a processor whose inter-processor bit is already pending, and is not dropped in the same write, leaves the bit set and pulses that processor's `dupIpi` bit for one cycle.
- R5: A drop request for a processor whose inter-processor bit is not pending pulses that processor's `staleIpi` bit for one cycle.
- R6: A cycle with `tick` high sets the timer pending bit and `tmrIrq` of every configured processor from the next cycle. When a timer drop for a processor arrives in the same cycle, that processor's bit still ends up set.
- R7: Bit 28 of an address-0 write is accepted and has no effect. An address-0 write in which all three masks are zero and bit 28 is clear pulses `badWrite` for one cycle and changes nothing.
- R8: The dedicated registers take their mask from data bits 3:0. A write to address 1 drops inter-processor interrupts, a write to address 2 drops timer interrupts, and a write to address 3 raises inter-processor interrupts. A write with a zero mask, and any write to address 4 or above, pulses `badWrite` and changes nothing.
- R9: A read is answered one cycle later with `rdValid` high. At address 0 the data holds inter-processor pending in bits 11:8, timer pending in bits 7:4 and the requester's `reqCpuId` in bits 1:0. Addresses 1 and 2 return the inter-processor and timer pending vectors in bits 3:0. Every other address, and every bit not named here, reads 0. The data reflects the state before the clock edge that samples the read.
- R10: Mask bits for processors at or above `NUM_CPU` are ignored, and the output lanes for those processors stay low. A mask that becomes empty after this trimming counts as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick; posts the timer interrupt to every processor |
| regValid | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | 64 | Write data |
| reqCpuId | input | 2 | Identity of the accessing processor |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 64 | Read data |
| ipiIrq | output | 4 | Inter-processor interrupt level, per processor |
| tmrIrq | output | 4 | Timer interrupt level, per processor |
| dupIpi | output | 4 | One-cycle pulse: request for an interrupt already pending |
| staleIpi | output | 4 | One-cycle pulse: drop of an interrupt that was not pending |
| badWrite | output | 1 | One-cycle pulse: write with no effect or to an unmapped address |

## Verification
The bench goes after the same-write drop-and-raise ordering. A design that applies the drop last would leave the processor idle and would also report a false duplicate. It checks a tick that lands together with a timer drop, where the wrong priority loses a timer interrupt. It checks masks that contain only out-of-range processor bits, which must be rejected rather than treated as valid writes. It also checks reads that coincide with updates, where a design that forwards the new state would return the wrong pending vector.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int MAX_CPU   = 4;
  localparam int REG_W     = 64;

  // control-word field positions (software-visible)
  localparam int REQ_LO    = 12;
  localparam int DROP_LO   = 8;
  localparam int TDROP_LO  = 4;
  localparam int NXM_BIT   = 28;

  // word addresses
  localparam int ADR_CTL   = 0;
  localparam int ADR_IPEND = 1;
  localparam int ADR_TPEND = 2;
  localparam int ADR_IREQ  = 3;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_CTL,
    RD_IPEND,
    RD_TPEND
  } rdSel_e;

  typedef struct packed {
    logic [MAX_CPU-1:0] ipiSet;
    logic [MAX_CPU-1:0] ipiClr;
    logic [MAX_CPU-1:0] tmrClr;
    logic               rdEn;
    rdSel_e             rdSel;
  } xirqStrobe_t;

endpackage

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output xirqStrobe_t       st,
  output logic              badWrite
);

  localparam logic [MAX_CPU-1:0] CPU_MASK = MAX_CPU'((1 << NUM_CPU) - 1);

  logic [MAX_CPU-1:0] reqF, dropF, tdropF, dedF;
  logic               nxmAck, wrEn, rdEn, badNow;
  logic               unusedWdata;

  assign reqF   = regWdata[REQ_LO   +: MAX_CPU] & CPU_MASK;
  assign dropF  = regWdata[DROP_LO  +: MAX_CPU] & CPU_MASK;
  assign tdropF = regWdata[TDROP_LO +: MAX_CPU] & CPU_MASK;
  assign dedF   = regWdata[MAX_CPU-1:0]         & CPU_MASK;
  assign nxmAck = regWdata[NXM_BIT];
  assign wrEn   = regValid &  regWrite;
  assign rdEn   = regValid & ~regWrite;

  assign unusedWdata = ^{regWdata[REG_W-1:NXM_BIT+1], regWdata[NXM_BIT-1:REQ_LO+MAX_CPU]};

  always_comb begin
    st       = '0;
    st.rdSel = RD_ZERO;
    badNow   = 1'b0;
    if (rdEn) begin
      st.rdEn = 1'b1;
      if      (regAddr == ADDR_W'(ADR_CTL))   st.rdSel = RD_CTL;
      else if (regAddr == ADDR_W'(ADR_IPEND)) st.rdSel = RD_IPEND;
      else if (regAddr == ADDR_W'(ADR_TPEND)) st.rdSel = RD_TPEND;
    end
    if (wrEn) begin
      if (regAddr == ADDR_W'(ADR_CTL)) begin
        if ((reqF | dropF | tdropF) != '0 || nxmAck) begin
          st.ipiSet = reqF;
          st.ipiClr = dropF;
          st.tmrClr = tdropF;
        end else begin
          badNow = 1'b1;
        end
      end else if (regAddr == ADDR_W'(ADR_IPEND)) begin
        if (dedF != '0) st.ipiClr = dedF;
        else            badNow    = 1'b1;
      end else if (regAddr == ADDR_W'(ADR_TPEND)) begin
        if (dedF != '0) st.tmrClr = dedF;
        else            badNow    = 1'b1;
      end else if (regAddr == ADDR_W'(ADR_IREQ)) begin
        if (dedF != '0) st.ipiSet = dedF;
        else            badNow    = 1'b1;
      end else begin
        badNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) badWrite <= 1'b0;
    else       badWrite <= badNow;
  end

  // R7 / R8: a rejected write pulses the error flag on the following cycle
  a_r7_bad_flagged: assert property (@(posedge clk) disable iff (!rstN)
    badNow |=> badWrite);

  // R8: a read never raises the error flag
  a_r8_read_not_bad: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> !badWrite);

endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  xirqStrobe_t        st,
  input  logic [1:0]         reqCpuId,
  output logic [MAX_CPU-1:0] ipiPend,
  output logic [MAX_CPU-1:0] tmrPend,
  output logic [MAX_CPU-1:0] dupIpi,
  output logic [MAX_CPU-1:0] staleIpi,
  output logic               rdValid,
  output logic [REG_W-1:0]   rdData
);

  localparam logic [MAX_CPU-1:0] CPU_MASK = MAX_CPU'((1 << NUM_CPU) - 1);

  for (genvar g = 0; g < MAX_CPU; g++) begin : g_lane
    if (g < NUM_CPU) begin : g_live
      logic ipiQ, tmrQ, dupQ, staleQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ipiQ   <= 1'b0;
          tmrQ   <= 1'b0;
          dupQ   <= 1'b0;
          staleQ <= 1'b0;
        end else begin
          // drop first, then request: a request in the same write wins
          ipiQ   <= (ipiQ & ~st.ipiClr[g]) | st.ipiSet[g];
          dupQ   <= st.ipiSet[g] & ipiQ & ~st.ipiClr[g];
          staleQ <= st.ipiClr[g] & ~ipiQ;
          // tick outranks a same-cycle timer drop
          tmrQ   <= tick | (tmrQ & ~st.tmrClr[g]);
        end
      end
      assign ipiPend[g]  = ipiQ;
      assign tmrPend[g]  = tmrQ;
      assign dupIpi[g]   = dupQ;
      assign staleIpi[g] = staleQ;
    end else begin : g_idle
      assign ipiPend[g]  = 1'b0;
      assign tmrPend[g]  = 1'b0;
      assign dupIpi[g]   = 1'b0;
      assign staleIpi[g] = 1'b0;
    end
  end

  logic [REG_W-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    unique case (st.rdSel)
      RD_CTL: begin
        rdNext[DROP_LO  +: MAX_CPU] = ipiPend;
        rdNext[TDROP_LO +: MAX_CPU] = tmrPend;
        rdNext[1:0]                 = reqCpuId;
      end
      RD_IPEND: rdNext[MAX_CPU-1:0] = ipiPend;
      RD_TPEND: rdNext[MAX_CPU-1:0] = tmrPend;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.rdEn;
      if (st.rdEn) rdData <= rdNext;
    end
  end

  a_r2_ipi_posted: assert property (@(posedge clk) disable iff (!rstN)
    (|st.ipiSet) |=> ((ipiPend & $past(st.ipiSet)) == $past(st.ipiSet)));

  a_r3_ipi_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (|(st.ipiClr & ~st.ipiSet)) |=> ((ipiPend & $past(st.ipiClr & ~st.ipiSet)) == '0));

  a_r5_stale_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (|(st.ipiClr & ~ipiPend)) |=> (|staleIpi));

  a_r6_tick_posts_all: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (tmrPend == CPU_MASK));

  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    st.rdEn |=> rdValid);

  a_r10_upper_lanes_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((ipiPend | tmrPend | dupIpi | staleIpi) & ~CPU_MASK) == '0);

endmodule

// File: rtl/xcpu_irq_hub.sv
module xcpu_irq_hub
  import xirq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  input  logic [1:0]         reqCpuId,
  output logic               rdValid,
  output logic [REG_W-1:0]   rdData,
  output logic [MAX_CPU-1:0] ipiIrq,
  output logic [MAX_CPU-1:0] tmrIrq,
  output logic [MAX_CPU-1:0] dupIpi,
  output logic [MAX_CPU-1:0] staleIpi,
  output logic               badWrite
);

  xirqStrobe_t strobe;

  xirq_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .st       (strobe),
    .badWrite (badWrite)
  );

  xirq_datapath #(.NUM_CPU(NUM_CPU)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .st       (strobe),
    .reqCpuId (reqCpuId),
    .ipiPend  (ipiIrq),
    .tmrPend  (tmrIrq),
    .dupIpi   (dupIpi),
    .staleIpi (staleIpi),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: tb/xcpu_irq_hub_tb.sv
module xcpu_irq_hub_tb;

  localparam int NC = 3;               // three live processors: lane 3 checks R10
  localparam logic [3:0] CM = 4'b0111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [1:0]  reqCpuId = '0;
  logic        rdValid;
  logic [63:0] rdData;
  logic [3:0]  ipiIrq, tmrIrq, dupIpi, staleIpi;
  logic        badWrite;

  always #10 clk = ~clk;

  xcpu_irq_hub #(.NUM_CPU(NC), .ADDR_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .reqCpuId(reqCpuId),
    .rdValid(rdValid), .rdData(rdData), .ipiIrq(ipiIrq), .tmrIrq(tmrIrq),
    .dupIpi(dupIpi), .staleIpi(staleIpi), .badWrite(badWrite)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] mIpi = '0;
  logic [3:0] mTmr = '0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one access cycle; expectations come from the requirement model
  task automatic op(input logic acc, input logic wr, input logic [3:0] adr,
                    input logic [63:0] d, input logic tk, input logic [1:0] cid,
                    input string tag);
    logic [3:0] set, clr, tclr, eDup, eStale, eIpi, eTmr;
    logic eBad;
    logic [63:0] eRd;
    set = '0; clr = '0; tclr = '0; eBad = 1'b0; eRd = '0;
    if (acc && wr) begin
      case (adr)
        4'd0: begin
          set = d[15:12] & CM; clr = d[11:8] & CM; tclr = d[7:4] & CM;
          if (set == 0 && clr == 0 && tclr == 0 && !d[28]) eBad = 1'b1;
        end
        4'd1: begin clr  = d[3:0] & CM; eBad = (clr  == 0); end
        4'd2: begin tclr = d[3:0] & CM; eBad = (tclr == 0); end
        4'd3: begin set  = d[3:0] & CM; eBad = (set  == 0); end
        default: eBad = 1'b1;
      endcase
      if (eBad) begin set = '0; clr = '0; tclr = '0; end
    end
    if (acc && !wr) begin
      case (adr)
        4'd0: eRd = (64'(mIpi) << 8) | (64'(mTmr) << 4) | 64'(cid);
        4'd1: eRd = 64'(mIpi);
        4'd2: eRd = 64'(mTmr);
        default: eRd = '0;
      endcase
    end
    eDup   = set & mIpi & ~clr;
    eStale = clr & ~mIpi;
    eIpi   = (mIpi & ~clr) | set;
    eTmr   = (mTmr & ~tclr) | (tk ? CM : 4'b0);

    regValid = acc; regWrite = wr; regAddr = adr; regWdata = d; tick = tk; reqCpuId = cid;
    @(posedge clk);
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; tick = 1'b0;

    chk(tag, "ipiIrq (R2)", 64'(ipiIrq), 64'(eIpi));
    chk(tag, "tmrIrq (R6)", 64'(tmrIrq), 64'(eTmr));
    chk(tag, "dupIpi (R4)", 64'(dupIpi), 64'(eDup));
    chk(tag, "staleIpi (R5)", 64'(staleIpi), 64'(eStale));
    chk(tag, "badWrite (R7)", 64'(badWrite), 64'(eBad));
    chk(tag, "rdValid (R9)", 64'(rdValid), 64'(acc && !wr));
    if (acc && !wr) chk(tag, "rdData (R9)", rdData, eRd);
    mIpi = eIpi; mTmr = eTmr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "ipiIrq in reset", 64'(ipiIrq), 64'd0);
    chk("R1", "tmrIrq in reset", 64'(tmrIrq), 64'd0);
    chk("R1", "flags in reset", 64'({dupIpi, staleIpi, badWrite, rdValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    op(1, 1, 4'd0, 64'h1000, 0, 0, "R2");            // raise processor 0
    op(1, 1, 4'd0, 64'h1000, 0, 0, "R4");            // duplicate
    op(1, 1, 4'd0, 64'h1100, 0, 0, "R3");            // drop+raise same processor
    op(1, 1, 4'd0, 64'h0200, 0, 0, "R5");            // stale drop of processor 1
    op(1, 1, 4'd0, 64'h0100, 0, 0, "R3");            // drop processor 0
    op(0, 0, 4'd0, 64'h0,    1, 0, "R6");            // tick alone
    op(1, 1, 4'd0, 64'h0010, 1, 0, "R6");            // tick beats timer drop
    op(1, 1, 4'd2, 64'h3,    0, 0, "R8");            // dedicated timer drop
    op(1, 1, 4'd0, 64'h0,    0, 0, "R7");            // empty control write
    op(1, 1, 4'd0, 64'h1000_0000, 0, 0, "R7");       // acknowledge bit only
    op(1, 1, 4'd3, 64'h0,    0, 0, "R8");            // zero dedicated mask
    op(1, 1, 4'd3, 64'hA,    0, 0, "R10");           // lane 3 trimmed, lane 1 raised
    op(1, 1, 4'd0, 64'h8000, 0, 0, "R10");           // only out-of-range bit: rejected
    op(1, 1, 4'd9, 64'h1,    0, 0, "R8");            // unmapped address
    op(1, 0, 4'd0, 64'h0,    0, 2'd2, "R9");
    op(1, 0, 4'd1, 64'h0,    1, 2'd1, "R9");         // read beside tick: old state
    op(1, 0, 4'd2, 64'h0,    0, 2'd0, "R9");
    op(1, 0, 4'd3, 64'h0,    0, 2'd3, "R9");
    op(1, 1, 4'd1, 64'hFFFF_FFFF_FFFF_FFF2, 0, 0, "R8");

    for (int i = 0; i < 400; i++) begin
      int k;
      logic tk;
      logic [63:0] d;
      k  = $urandom_range(0, 9);
      tk = ($urandom_range(0, 5) == 0);
      d  = {$urandom(), 32'h0};
      if (k <= 3) begin
        d[15:12] = 4'($urandom_range(0, 15));
        d[11:8]  = ($urandom_range(0, 1) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
        d[7:4]   = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
        d[28]    = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 7) == 0) d[15:4] = '0;
        op(1, 1, 4'd0, d, tk, 0, "R2");
      end else if (k <= 6) begin
        d[3:0] = 4'($urandom_range(0, 15));
        op(1, 1, 4'($urandom_range(1, 3)), d, tk, 0, "R8");
      end else if (k == 7) begin
        op(1, 1, 4'($urandom_range(4, 15)), d, tk, 0, "R8");
      end else begin
        op(1, 0, 4'($urandom_range(0, 4)), 64'h0, tk, 2'($urandom_range(0, 3)), "R9");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule